// File: doc/BRIEF.md
# FPU Control Register Access Unit

This unit serves move-from and move-to operations on floating-point control registers for a 32-bit processor pipeline. For each access strobe it decodes the control register index. On a read it returns the selected value in the same cycle. On a write it produces the resulting side effect. Read data and the exception flag are combinational with the strobe. The one piece of state the unit owns is the floating-point register mode bit, and it changes on the following clock edge.

Beside the ordinary identification and condition-code views, the unit provides a user-mode alias to the register mode bit. This alias has three gates:
- An alias-present flag inside the identification word gates the whole alias.
- A configuration enable decides whether the alias works or traps.
- A write through the alias is honoured only when its source general-purpose register is register zero.

A gated access that is not enabled raises a reserved-instruction exception for the cycle of that access.

Top module: `fpu_ctrl_access`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mode_bit` becomes 0. With no strobe, `rd_data` is 0 and `ri_pulse` and `cc_wr_en` are low.
- R2: A read (`acc_valid`=1, `acc_write`=0) of index 0 returns `fpu_id` unchanged on `rd_data`.
- R3: A read of index 1 returns `{31'b0, mode_bit}` when `fpu_id[PRESENT_BIT]` (bit 28 by default) is 1 and `cfg_alias_en` is 1.
- R4: A read of index 1 with the present bit set and `cfg_alias_en` clear raises `ri_pulse` in that cycle only, and `rd_data` is 0.
- R5: A read of index 1 with the present bit clear returns 0 and raises no exception.
- R6: A write to index 1 clears `mode_bit` and a write to index 4 sets it, effective at the next clock edge, when the present bit is set, `src_gpr` is 0 and `cfg_alias_en` is 1.
- R7: A write to index 1 or 4 with the present bit clear or `src_gpr` nonzero leaves `mode_bit` unchanged and raises no exception.
- R8: A write to index 1 or 4 that passes the present/`src_gpr` gate while `cfg_alias_en` is clear raises `ri_pulse` for that cycle and leaves `mode_bit` unchanged.
- R9: A read of index 25 returns `fcsr_in[31:25]` in bits 7:1 and `fcsr_in[23]` in bit 0, with bits 31:8 zero.
- R10: A write to index 25 asserts `cc_wr_en`, with `cc_wr_data` = `wr_data[7:0]`, only when `wr_data[31:8]` is zero. Otherwise the write is dropped.
- R11: Reads of any other index return 0. Writes to any other index change nothing and raise no exception.
- R12: `ri_pulse` is never high without `acc_valid`. In a cycle without a strobe, `mode_bit` holds its value across the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| ctl_idx | input | 5 | Control register index |
| src_gpr | input | 5 | Source general-purpose register number of a write |
| wr_data | input | 32 | Write data from the source register |
| fpu_id | input | 32 | FPU identification word, carries the alias-present flag |
| fcsr_in | input | 32 | Current FPU control/status word |
| cfg_alias_en | input | 1 | Configuration enable for the mode alias |
| rd_data | output | 32 | Read result, valid with a read strobe |
| mode_bit | output | 1 | Registered floating-point register mode bit |
| ri_pulse | output | 1 | Reserved-instruction exception for the current access |
| cc_wr_en | output | 1 | Accepted write to the condition-code view |
| cc_wr_data | output | 8 | Low byte written through the condition-code view |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, 5-bit indices, and the alias-present flag at bit 28 of the identification word. With these values the three alias gates can be driven independently, so every combination of present flag, enable and source register zero or nonzero is reached. Random indices are biased toward 0, 1, 4 and 25, and the rest spread over the other indices. Mode writes follow each other back to back, so set-after-set, clear-after-set and trap-while-set sequences all occur.

// File: rtl/fcra_pkg.sv
// Package: shared decode record of the FPU control register access unit.
// Assumes index values 0, 1, 4 and 25 are fixed by the instruction encoding.
package fcra_pkg;
    localparam int unsigned FCRA_IDX_ID  = 0;
    localparam int unsigned FCRA_IDX_CLR = 1;
    localparam int unsigned FCRA_IDX_SET = 4;
    localparam int unsigned FCRA_IDX_CC  = 25;

    typedef struct packed {
        logic rd_id;     // return identification word
        logic rd_mode;   // return mode bit
        logic rd_cc;     // return packed condition-code view
        logic mode_clr;  // clear mode bit at next edge
        logic mode_set;  // set mode bit at next edge
        logic cc_wr;     // accepted condition-code write
        logic trap;      // reserved-instruction exception
    } fcra_dec_t;
endpackage

// File: rtl/fcra_decode.sv
// Module: fcra_decode
// Turns one access (index, direction, gates) into a one-hot-ish action record.
// Assumes the caller qualifies everything with the strobe; purely combinational.
module fcra_decode
    import fcra_pkg::*;
#(
    parameter int unsigned XLEN        = 32,
    parameter int unsigned IDX_W       = 5,
    parameter int unsigned GPR_W       = 5,
    parameter int unsigned PRESENT_BIT = 28
) (
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [IDX_W-1:0] ctl_idx,
    input  logic [GPR_W-1:0] src_gpr,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [XLEN-1:0]  fpu_id,
    input  logic             cfg_alias_en,
    output fcra_dec_t        dec
);
    localparam logic [IDX_W-1:0] K_ID  = IDX_W'(FCRA_IDX_ID);
    localparam logic [IDX_W-1:0] K_CLR = IDX_W'(FCRA_IDX_CLR);
    localparam logic [IDX_W-1:0] K_SET = IDX_W'(FCRA_IDX_SET);
    localparam logic [IDX_W-1:0] K_CC  = IDX_W'(FCRA_IDX_CC);

    logic present;
    logic wr_gate;
    logic rd_s;
    logic wr_s;
    logic hi_zero;

    assign present = fpu_id[PRESENT_BIT];
    assign wr_gate = present && (src_gpr == '0);
    assign rd_s    = acc_valid && !acc_write;
    assign wr_s    = acc_valid && acc_write;
    assign hi_zero = (wr_data[XLEN-1:8] == '0);

    // Map index, direction and gates onto the action record.
    always_comb begin
        dec = '0;
        if (rd_s) begin
            unique case (ctl_idx)
                K_ID:    dec.rd_id = 1'b1;
                K_CLR: begin
                    if (present && cfg_alias_en) dec.rd_mode = 1'b1;
                    else if (present)            dec.trap    = 1'b1;
                end
                K_CC:    dec.rd_cc = 1'b1;
                default: ;
            endcase
        end else if (wr_s) begin
            unique case (ctl_idx)
                K_CLR, K_SET: begin
                    if (wr_gate && cfg_alias_en) begin
                        dec.mode_clr = (ctl_idx == K_CLR);
                        dec.mode_set = (ctl_idx == K_SET);
                    end else if (wr_gate) begin
                        dec.trap = 1'b1;
                    end
                end
                K_CC:    dec.cc_wr = hi_zero;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/fcra_mode_reg.sv
// Module: fcra_mode_reg
// Holds the floating-point register mode bit.
// Assumes clear and set are never requested together.
module fcra_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req,
    input  logic set_req,
    output logic mode_q
);
    // Apply a clear or set request at the clock edge; reset to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_q <= 1'b0;
        else if (set_req) mode_q <= 1'b1;
        else if (clr_req) mode_q <= 1'b0;
    end

    // R6
    no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_req && set_req));
endmodule

// File: rtl/fcra_read_mux.sv
// Module: fcra_read_mux
// Builds the read result from the decoded read selects.
// Assumes at most one select is active; zero when none is.
module fcra_read_mux
    import fcra_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  fcra_dec_t       dec,
    input  logic [XLEN-1:0] fpu_id,
    input  logic [XLEN-1:0] fcsr_in,
    input  logic            mode_q,
    output logic [XLEN-1:0] rd_data
);
    logic [XLEN-1:0] cc_view;
    logic [XLEN-1:0] mode_view;

    assign cc_view   = XLEN'({fcsr_in[31:25], fcsr_in[23]});
    assign mode_view = XLEN'(mode_q);

    // Select one read view, or zero.
    always_comb begin
        rd_data = '0;
        if (dec.rd_id)   rd_data = fpu_id;
        if (dec.rd_mode) rd_data = mode_view;
        if (dec.rd_cc)   rd_data = cc_view;
    end
endmodule

// File: rtl/fpu_ctrl_access.sv
// Module: fpu_ctrl_access (top)
// FPU control register read/write unit with the gated user-mode alias
// to the register mode bit. Assumes one access per strobe cycle.
module fpu_ctrl_access
    import fcra_pkg::*;
#(
    parameter int unsigned XLEN        = 32,
    parameter int unsigned IDX_W       = 5,
    parameter int unsigned GPR_W       = 5,
    parameter int unsigned PRESENT_BIT = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [IDX_W-1:0] ctl_idx,
    input  logic [GPR_W-1:0] src_gpr,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [XLEN-1:0]  fpu_id,
    input  logic [XLEN-1:0]  fcsr_in,
    input  logic             cfg_alias_en,
    output logic [XLEN-1:0]  rd_data,
    output logic             mode_bit,
    output logic             ri_pulse,
    output logic             cc_wr_en,
    output logic [7:0]       cc_wr_data
);
    fcra_dec_t dec;

    fcra_decode #(
        .XLEN(XLEN), .IDX_W(IDX_W), .GPR_W(GPR_W), .PRESENT_BIT(PRESENT_BIT)
    ) u_decode (
        .acc_valid(acc_valid), .acc_write(acc_write), .ctl_idx(ctl_idx),
        .src_gpr(src_gpr), .wr_data(wr_data), .fpu_id(fpu_id),
        .cfg_alias_en(cfg_alias_en), .dec(dec)
    );

    fcra_mode_reg u_mode (
        .clk(clk), .rst_n(rst_n),
        .clr_req(dec.mode_clr), .set_req(dec.mode_set), .mode_q(mode_bit)
    );

    fcra_read_mux #(.XLEN(XLEN)) u_rdmux (
        .dec(dec), .fpu_id(fpu_id), .fcsr_in(fcsr_in),
        .mode_q(mode_bit), .rd_data(rd_data)
    );

    assign ri_pulse   = dec.trap;
    assign cc_wr_en   = dec.cc_wr;
    assign cc_wr_data = wr_data[7:0];

    logic alias_idx;
    assign alias_idx = (ctl_idx == IDX_W'(FCRA_IDX_CLR)) ||
                       (ctl_idx == IDX_W'(FCRA_IDX_SET));

    // R12
    ri_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ri_pulse |-> acc_valid);
    // R12
    idle_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> $stable(mode_bit));
    // R8
    trap_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ri_pulse |=> $stable(mode_bit));
    // R4
    trap_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ri_pulse |-> (rd_data == '0));
    // R6
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && ctl_idx == IDX_W'(FCRA_IDX_SET) &&
         fpu_id[PRESENT_BIT] && src_gpr == '0 && cfg_alias_en) |=> mode_bit);
    // R6
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && ctl_idx == IDX_W'(FCRA_IDX_CLR) &&
         fpu_id[PRESENT_BIT] && src_gpr == '0 && cfg_alias_en) |=> !mode_bit);
    // R7
    ungated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && alias_idx &&
         (!fpu_id[PRESENT_BIT] || src_gpr != '0)) |=> $stable(mode_bit));
    // R7
    ungated_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (!fpu_id[PRESENT_BIT] || src_gpr != '0))
        |-> !ri_pulse);
    // R10
    cc_wr_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_wr_en |-> (wr_data[XLEN-1:8] == '0));
endmodule

// File: tb/fpu_ctrl_access_bench.sv
module fpu_ctrl_access_bench;
    localparam int PB = 28;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid, acc_write, cfg_alias_en;
    logic [4:0]  ctl_idx, src_gpr;
    logic [31:0] wr_data, fpu_id, fcsr_in, rd_data;
    logic        mode_bit, ri_pulse, cc_wr_en;
    logic [7:0]  cc_wr_data;

    int n_chk = 0;
    int n_bad = 0;
    logic exp_mode = 1'b0;

    always #5 clk = ~clk;

    fpu_ctrl_access u_fpu_ctrl_access (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .ctl_idx(ctl_idx), .src_gpr(src_gpr), .wr_data(wr_data),
        .fpu_id(fpu_id), .fcsr_in(fcsr_in), .cfg_alias_en(cfg_alias_en),
        .rd_data(rd_data), .mode_bit(mode_bit), .ri_pulse(ri_pulse),
        .cc_wr_en(cc_wr_en), .cc_wr_data(cc_wr_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic v, input logic w, input logic [4:0] i,
                                     input logic p, input logic e, input logic [4:0] s);
        if (!v) return "R12";
        if (!w) begin
            if (i == 0) return "R2";
            if (i == 1) return !p ? "R5" : (e ? "R3" : "R4");
            if (i == 25) return "R9";
            return "R11";
        end
        if (i == 1 || i == 4) return (!p || s != 0) ? "R7" : (e ? "R6" : "R8");
        if (i == 25) return "R10";
        return "R11";
    endfunction

    // Drive one access at the falling edge, check outputs, then the mode after the edge.
    task automatic apply(input logic v, input logic w, input logic [4:0] i,
                         input logic [4:0] s, input logic [31:0] d,
                         input logic [31:0] id, input logic [31:0] cs, input logic e);
        logic [31:0] x_rd;
        logic x_ri, x_cc, p, gate, nxt;
        string t;
        @(negedge clk);
        acc_valid = v; acc_write = w; ctl_idx = i; src_gpr = s; wr_data = d;
        fpu_id = id; fcsr_in = cs; cfg_alias_en = e;
        p = id[PB];
        gate = p && (s == 0);
        x_rd = 0; x_ri = 0; x_cc = 0; nxt = exp_mode;
        if (v && !w) begin
            if (i == 0) x_rd = id;
            else if (i == 1) begin
                if (p && e) x_rd = {31'b0, exp_mode};
                else if (p) x_ri = 1;
            end else if (i == 25) x_rd = {24'b0, cs[31:25], cs[23]};
        end else if (v && w) begin
            if (i == 1 || i == 4) begin
                if (gate && e) nxt = (i == 4);
                else if (gate) x_ri = 1;
            end else if (i == 25) x_cc = (d[31:8] == 0);
        end
        t = tag_of(v, w, i, p, e, s);
        #2;
        check({t, " rd_data"}, rd_data, x_rd);
        check({t, " ri_pulse"}, {31'b0, ri_pulse}, {31'b0, x_ri});
        check({t, " cc_wr_en"}, {31'b0, cc_wr_en}, {31'b0, x_cc});
        if (x_cc) check({t, " cc_wr_data"}, {24'b0, cc_wr_data}, {24'b0, d[7:0]});
        @(posedge clk);
        #1;
        exp_mode = nxt;
        check({t, " mode_bit"}, {31'b0, mode_bit}, {31'b0, exp_mode});
    endtask

    localparam logic [31:0] ID_P = 32'h1000_0093 | (32'h1 << PB);
    localparam logic [31:0] ID_N = 32'h0070_0093;

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [4:0] ri;
        logic [4:0] rs;
        logic [31:0] rid;
        void'($urandom(32'd1234));
        rst_n = 0; acc_valid = 0; acc_write = 0; ctl_idx = 0; src_gpr = 0;
        wr_data = 0; fpu_id = 0; fcsr_in = 0; cfg_alias_en = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 mode_bit", {31'b0, mode_bit}, 32'h0);
        check("R1 rd_data", rd_data, 32'h0);
        check("R1 ri_pulse", {31'b0, ri_pulse}, 32'h0);
        check("R1 cc_wr_en", {31'b0, cc_wr_en}, 32'h0);
        @(negedge clk); rst_n = 1;

        // Directed corners
        apply(1, 0, 0, 0, 0, ID_P, 0, 1);                 // R2
        apply(1, 1, 4, 0, 32'hFFFF, ID_P, 0, 1);          // R6 set
        apply(1, 0, 1, 0, 0, ID_P, 0, 1);                 // R3 reads 1
        apply(1, 0, 1, 0, 0, ID_P, 0, 0);                 // R4 trap
        apply(1, 0, 1, 0, 0, ID_N, 0, 1);                 // R5
        apply(1, 1, 1, 3, 0, ID_P, 0, 1);                 // R7 src nonzero
        apply(1, 1, 1, 0, 0, ID_N, 0, 1);                 // R7 not present
        apply(1, 1, 1, 0, 0, ID_P, 0, 0);                 // R8 trap, stays set
        apply(1, 1, 1, 0, 0, ID_P, 0, 1);                 // R6 clear
        apply(1, 1, 4, 0, 0, ID_P, 0, 0);                 // R8 trap, stays clear
        apply(1, 0, 25, 0, 0, ID_P, 32'hFE80_0000, 1);    // R9 all ones packed
        apply(1, 0, 25, 0, 0, ID_P, 32'h017F_FFFF, 1);    // R9 excluded bits
        apply(1, 1, 25, 0, 32'h0000_00A5, ID_P, 0, 1);    // R10 accepted
        apply(1, 1, 25, 0, 32'h0000_0100, ID_P, 0, 1);    // R10 dropped
        apply(1, 0, 7, 0, 0, ID_P, 32'hFFFF_FFFF, 1);     // R11
        apply(1, 1, 2, 0, 0, ID_P, 0, 0);                 // R11
        apply(0, 1, 4, 0, 0, ID_P, 0, 1);                 // R12 no strobe

        // Constrained random
        for (int k = 0; k < 3000; k++) begin
            case ($urandom % 6)
                0: ri = 0;
                1, 2: ri = 1;
                3: ri = 4;
                4: ri = 25;
                default: ri = 5'($urandom);
            endcase
            rs = ($urandom % 3 == 0) ? 5'($urandom) : 5'd0;
            rid = $urandom;
            rid[PB] = ($urandom % 4 != 0);
            apply(($urandom % 8) != 0, $urandom % 2, ri, rs,
                  ($urandom % 2) ? 32'($urandom % 256) : $urandom,
                  rid, $urandom, ($urandom % 3) != 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule